// File: doc/BRIEF.md
# Address-Pattern Memory Self-Test Engine

This block runs a self-contained built-in test over a single-port synchronous word RAM with 2**ADDR_W locations. A host starts it by writing a command word with the start bit set. The engine then makes two ascending sweeps over every location. The first sweep stores each location's own address as data, reads it back and compares it. The second sweep does the same with the bitwise complement of the address. While the test runs, the engine owns the RAM port and holds the terminal offline.

A clean finish sets a passed flag. The first mismatch stops the test, records the failing location and leaves passed low. Either kind of finish can raise a one-cycle interrupt when interrupts are enabled. The passed flag stays low for the whole run, so a flag stuck at one can be seen by polling. The host may poll the status register during the run. Any access to a different register cancels the test without an interrupt.

Top module: `mem_bist_ctrl`

## Requirements
- R1: A host write (sel=1, we=1) to register address 0x03 with the start data bit set, while idle, makes busy_o high from the next cycle. A write to 0x03 with that bit clear, or with the bit set to another address, leaves busy_o low.
- R2: In the first sweep the engine writes every location in ascending order from 0, with data equal to the address zero-extended to DATA_W.
- R3: In the second sweep it again writes every location in ascending order from 0, with data equal to the bitwise inverse of the zero-extended address over all DATA_W bits.
- R4: Each location costs exactly 5 cycles per sweep: setup, write, read request, read capture, compare. A clean run therefore keeps busy_o high for exactly 10 * 2**ADDR_W cycles.
- R5: In each location slot the RAM is enabled only in the 2nd cycle (write) and the 3rd cycle (read of the same address). The RAM is never enabled while the engine is idle.
- R6: passed_o is 0 during every busy cycle and is cleared at start. It becomes 1 in the first cycle after a run that ends without a mismatch.
- R7: The first read-back that differs from the written pattern ends the test after that location's compare cycle, with failed_o=1, passed_o=0 and fail_addr_o equal to the failing location.
- R8: Each completed run, whether it passed or failed, gives exactly one single-cycle irq_o pulse when irq_en_i is 1, and none when it is 0.
- R9: Host accesses to register address 0x1C during a run have no effect: the run keeps its full length and its result.
- R10: A host access to any address other than 0x1C during a run aborts it. busy_o is low in the next cycle, passed_o=0, failed_o=0 and no irq_o is raised. A start write during a run counts as such an access.
- R11: offline_o is high in exactly the cycles in which busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_sel_i | input | 1 | Host register access strobe, one cycle per access |
| host_we_i | input | 1 | Access is a write |
| host_addr_i | input | REG_AW | Host register address |
| host_wd_start_i | input | 1 | Write-data bit in the start position of the command word |
| irq_en_i | input | 1 | Enables the completion interrupt |
| ram_en_o | output | 1 | RAM access enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | ADDR_W | RAM address |
| ram_wdata_o | output | DATA_W | RAM write data |
| ram_rdata_i | input | DATA_W | RAM read data, valid the cycle after the read request |
| busy_o | output | 1 | Test in progress |
| offline_o | output | 1 | Terminal must not use the bus |
| passed_o | output | 1 | Last run finished without a mismatch |
| failed_o | output | 1 | Last run stopped on a mismatch |
| fail_addr_o | output | ADDR_W | Location of the last mismatch |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
A wrong phase or address counter shows up on the RAM port within one 5-cycle slot, as an enable in the wrong cycle, a wrong address or a wrong pattern. It also changes the busy length from the exact 10 * 2**ADDR_W cycles. A comparator or capture fault shows up either as a false failure at a predictable cycle or as a missed failure from an injected stuck data bit. The bench predicts whether that bit is caught in the first or the second sweep and at which location, so the finish cycle and fail_addr_o expose the error. A faulty abort or status-read decode shows up in the cycle after the access, as busy_o still high or a run that ends early.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  typedef enum logic [2:0] {
    PH_SETUP,
    PH_WRITE,
    PH_RDREQ,
    PH_CAPT,
    PH_CMP
  } phase_t;
endpackage

// File: rtl/mbist_host_dec.sv
module mbist_host_dec #(
  parameter int REG_AW = 5,
  parameter logic [REG_AW-1:0] CMD_ADDR = 5'h03,
  parameter logic [REG_AW-1:0] STAT_ADDR = 5'h1C
) (
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              wd_start_i,
  input  logic              busy_i,
  output logic              start_o,
  output logic              abort_o
);
  assign start_o = sel_i & we_i & (addr_i == CMD_ADDR) & wd_start_i & ~busy_i;
  // only status polling is tolerated during a run
  assign abort_o = sel_i & busy_i & (addr_i != STAT_ADDR);
endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              mis_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              inv_o,
  output logic              cap_en_o,
  output logic              cmp_en_o,
  output logic              end_o,
  output logic              ram_en_o,
  output logic              ram_we_o
);
  localparam logic [ADDR_W-1:0] LAST_LOC = '1;

  phase_t            ph_q;
  logic              busy_q, inv_q;
  logic [ADDR_W-1:0] addr_q;
  logic              last_loc;

  assign last_loc = (addr_q == LAST_LOC);
  assign cap_en_o = busy_q & (ph_q == PH_CAPT);
  assign cmp_en_o = busy_q & (ph_q == PH_CMP);
  assign end_o    = cmp_en_o & ~abort_i & (mis_i | (last_loc & inv_q));
  assign ram_en_o = busy_q & ((ph_q == PH_WRITE) | (ph_q == PH_RDREQ));
  assign ram_we_o = busy_q & (ph_q == PH_WRITE);
  assign busy_o   = busy_q;
  assign addr_o   = addr_q;
  assign inv_o    = inv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ph_q   <= PH_SETUP;
      addr_q <= '0;
      inv_q  <= 1'b0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      ph_q   <= PH_SETUP;
      addr_q <= '0;
      inv_q  <= 1'b0;
    end else if (busy_q) begin
      case (ph_q)
        PH_SETUP: ph_q <= PH_WRITE;
        PH_WRITE: ph_q <= PH_RDREQ;
        PH_RDREQ: ph_q <= PH_CAPT;
        PH_CAPT:  ph_q <= PH_CMP;
        default: begin
          ph_q <= PH_SETUP;
          if (mis_i) begin
            busy_q <= 1'b0;
          end else if (last_loc) begin
            addr_q <= '0;
            if (inv_q) busy_q <= 1'b0;
            else       inv_q  <= 1'b1;
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
      endcase
    end
  end

  a_r5_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !ram_en_o);
  a_r4_setup_to_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && ph_q == PH_SETUP && !abort_i) |=> (busy_q && ph_q == PH_WRITE));
  a_r5_read_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && !abort_i) |=> (ram_en_o && !ram_we_o && addr_q == $past(addr_q)));
endmodule

// File: rtl/mbist_chk.sv
module mbist_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              inv_i,
  input  logic              cap_en_i,
  input  logic              cmp_en_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic              mis_o
);
  localparam int PAD_W = DATA_W - ADDR_W;

  logic [DATA_W-1:0] addr_ext, pat, cap_q;

  generate
    if (PAD_W > 0) begin : g_pad
      assign addr_ext = {{PAD_W{1'b0}}, addr_i};
    end else begin : g_nopad
      assign addr_ext = addr_i[DATA_W-1:0];
    end
  endgenerate

  assign pat     = inv_i ? ~addr_ext : addr_ext;
  assign wdata_o = pat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cap_q <= '0;
    else if (cap_en_i) cap_q <= rdata_i;
  end

  assign mis_o = cmp_en_i & (cap_q != pat);
endmodule

// File: rtl/mem_bist_ctrl.sv
module mem_bist_ctrl #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int REG_AW = 5,
  parameter logic [REG_AW-1:0] CMD_ADDR = 5'h03,
  parameter logic [REG_AW-1:0] STAT_ADDR = 5'h1C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_sel_i,
  input  logic              host_we_i,
  input  logic [REG_AW-1:0] host_addr_i,
  input  logic              host_wd_start_i,
  input  logic              irq_en_i,
  output logic              ram_en_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic              busy_o,
  output logic              offline_o,
  output logic              passed_o,
  output logic              failed_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic              irq_o
);
  logic              start, abort, busy, mis, inv, cap_en, cmp_en, fin;
  logic [ADDR_W-1:0] addr;
  logic              passed_q, failed_q, irq_q;
  logic [ADDR_W-1:0] fail_addr_q;

  mbist_host_dec #(.REG_AW(REG_AW), .CMD_ADDR(CMD_ADDR), .STAT_ADDR(STAT_ADDR)) u_dec (
    .sel_i(host_sel_i), .we_i(host_we_i), .addr_i(host_addr_i),
    .wd_start_i(host_wd_start_i), .busy_i(busy),
    .start_o(start), .abort_o(abort)
  );

  mbist_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .abort_i(abort), .mis_i(mis),
    .busy_o(busy), .addr_o(addr), .inv_o(inv), .cap_en_o(cap_en), .cmp_en_o(cmp_en),
    .end_o(fin), .ram_en_o(ram_en_o), .ram_we_o(ram_we_o)
  );

  mbist_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr), .inv_i(inv),
    .cap_en_i(cap_en), .cmp_en_i(cmp_en), .rdata_i(ram_rdata_i),
    .wdata_o(ram_wdata_o), .mis_o(mis)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      passed_q    <= 1'b0;
      failed_q    <= 1'b0;
      fail_addr_q <= '0;
      irq_q       <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (abort || start) begin
        passed_q <= 1'b0;
        failed_q <= 1'b0;
      end else if (fin) begin
        passed_q <= ~mis;
        failed_q <= mis;
        if (mis) fail_addr_q <= addr;
        irq_q <= irq_en_i;
      end
    end
  end

  assign ram_addr_o  = addr;
  assign busy_o      = busy;
  assign offline_o   = busy;
  assign passed_o    = passed_q;
  assign failed_o    = failed_q;
  assign fail_addr_o = fail_addr_q;
  assign irq_o       = irq_q;

  a_r1_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> busy_o);
  a_r6_passed_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !passed_o);
  a_r7_fail_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    failed_o |-> !passed_o);
  a_r8_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  a_r10_abort_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> (!busy_o && !irq_o && !passed_o && !failed_o));
endmodule

// File: tb/mem_bist_ctrl_test.sv
module mem_bist_ctrl_test;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int RAW = 5;
  localparam int D = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic           host_sel = 0, host_we = 0, host_wd = 0, irq_en = 0;
  logic [RAW-1:0] host_addr = '0;
  logic           ram_en, ram_we;
  logic [AW-1:0]  ram_addr, fail_addr;
  logic [DW-1:0]  ram_wdata;
  logic [DW-1:0]  ram_rdata = '0;
  logic           busy, offline, passed, failed, irq;

  mem_bist_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .host_sel_i(host_sel), .host_we_i(host_we),
    .host_addr_i(host_addr), .host_wd_start_i(host_wd), .irq_en_i(irq_en),
    .ram_en_o(ram_en), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata), .busy_o(busy),
    .offline_o(offline), .passed_o(passed), .failed_o(failed),
    .fail_addr_o(fail_addr), .irq_o(irq)
  );

  // RAM model with optional stuck data bit at one location
  logic [DW-1:0] mem [D];
  bit f_on = 0;
  int f_addr = 0, f_bit = 0;
  bit f_val = 0;

  function automatic logic [DW-1:0] rd_fault(logic [DW-1:0] v, int a);
    logic [DW-1:0] m;
    m = DW'(1) << f_bit;
    if (f_on && a == f_addr) return f_val ? (v | m) : (v & ~m);
    return v;
  endfunction

  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      else        ram_rdata <= rd_fault(mem[ram_addr], int'(ram_addr));
    end
  end

  function automatic logic [DW-1:0] exp_word(int a, bit inv);
    logic [DW-1:0] w;
    w = DW'(a);
    return inv ? ~w : w;
  endfunction

  int n_chk = 0, n_err = 0;
  bit fin = 0;

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // port monitor, one sample per cycle at the falling edge
  int cyc = 0, irq_cnt = 0, sched_bad = 0, pass_bad = 0, off_bad = 0;
  int pos, ph, loc;
  bit pinv;
  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (offline != busy) off_bad++;
    if (busy) begin
      pos  = cyc;
      ph   = pos % 5;
      loc  = (pos / 5) % D;
      pinv = (pos / (5 * D)) != 0;
      if (passed) pass_bad++;
      if (ph == 1) begin
        if (!(ram_en && ram_we && int'(ram_addr) == loc && ram_wdata == exp_word(loc, pinv)))
          sched_bad++;
      end else if (ph == 2) begin
        if (!(ram_en && !ram_we && int'(ram_addr) == loc)) sched_bad++;
      end else if (ram_en) begin
        sched_bad++;
      end
      cyc++;
    end else if (ram_en) begin
      sched_bad++;
    end
  end

  // mode 0: none, 1: one access at busy cycle icyc, 2: periodic status reads
  task automatic run(input int mode, input int icyc, input logic [RAW-1:0] iaddr,
                     input bit iwe, input bit ien, output int cycles);
    int k;
    irq_en = ien;
    repeat (2) @(negedge clk);
    cyc = 0; irq_cnt = 0; sched_bad = 0; pass_bad = 0; off_bad = 0;
    @(negedge clk);
    host_sel = 1; host_we = 1; host_addr = 5'h03; host_wd = 1;
    @(negedge clk);
    host_sel = 0; host_wd = 0;
    chk("R1 busy after start", busy, 1);
    k = 1;
    while (busy && k < 12 * D) begin
      if (mode == 1 && k == icyc) begin
        host_sel = 1; host_we = iwe; host_addr = iaddr; host_wd = 1;
      end
      if (mode == 2 && (k % 7) == 3) begin
        host_sel = 1; host_we = 0; host_addr = 5'h1C;
      end
      @(negedge clk);
      host_sel = 0; host_wd = 0;
      k++;
    end
    cycles = k - 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!fin) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int cycles, idx, c;
    bit b0;
    logic [RAW-1:0] a;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset busy", busy, 0);
    chk("R6 reset passed", passed, 0);
    chk("R7 reset failed", failed, 0);
    chk("R8 reset irq", irq, 0);
    chk("R5 reset ram_en", ram_en, 0);

    // R1: start bit clear, and start bit to wrong address
    host_sel = 1; host_we = 1; host_addr = 5'h03; host_wd = 0;
    @(negedge clk);
    host_addr = 5'h05; host_wd = 1;
    @(negedge clk);
    host_sel = 0; host_wd = 0;
    @(negedge clk);
    chk("R1 no start without bit / at other address", busy, 0);

    // clean run, interrupt on
    run(0, 0, '0, 0, 1, cycles);
    chk("R4 clean run length", cycles, 10 * D);
    chk("R2/R3/R5 RAM schedule and patterns", sched_bad, 0);
    chk("R6 passed low while busy", pass_bad, 0);
    chk("R6 passed after clean run", passed, 1);
    chk("R7 failed clear on clean run", failed, 0);
    chk("R8 one irq pulse", irq_cnt, 1);
    chk("R11 offline tracks busy", off_bad, 0);

    // clean run, interrupt off
    run(0, 0, '0, 0, 0, cycles);
    chk("R8 no irq when disabled", irq_cnt, 0);
    chk("R6 passed second run", passed, 1);

    // stuck-bit faults: directed last-location second sweep, then random
    for (int i = 0; i < 5; i++) begin
      if (i == 0) begin
        f_addr = D - 1; f_bit = 0; f_val = 1;
      end else begin
        f_addr = $urandom_range(0, D - 1);
        f_bit  = $urandom_range(0, DW - 1);
        f_val  = 1'($urandom_range(0, 1));
      end
      f_on = 1;
      b0 = exp_word(f_addr, 0)[f_bit];
      idx = (b0 != f_val) ? f_addr : D + f_addr;
      run(0, 0, '0, 0, 1, cycles);
      chk("R7 fail stop cycle", cycles, 5 * (idx + 1));
      chk("R7 failed set", failed, 1);
      chk("R7 passed low on fail", passed, 0);
      chk("R7 fail address", fail_addr, f_addr);
      chk("R8 irq on failed run", irq_cnt, 1);
      chk("R2/R3/R5 schedule up to fail", sched_bad, 0);
      f_on = 0;
    end

    // R9: status polling during run
    run(2, 0, '0, 0, 1, cycles);
    chk("R9 status reads keep full length", cycles, 10 * D);
    chk("R9 status reads keep pass", passed, 1);

    // R10: aborts at random points to random non-status addresses
    for (int i = 0; i < 4; i++) begin
      c = $urandom_range(1, 10 * D - 1);
      do a = RAW'($urandom_range(0, 31)); while (a == 5'h1C);
      if (i == 3) a = 5'h03;
      run(1, c, a, (i == 3) ? 1'b1 : 1'($urandom_range(0, 1)), 1, cycles);
      chk("R10 abort stops next cycle", cycles, c);
      chk("R10 abort passed low", passed, 0);
      chk("R10 abort failed low", failed, 0);
      chk("R10 abort raises no irq", irq_cnt, 0);
    end

    fin = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule